// File: doc/BRIEF.md
# Three-Wire Codec Configuration Master

This block is a bus master that sets up an audio codec over a three-wire serial link made of a clock line, a mode line and a bidirectional data line. A host asks for one transfer at a time. It supplies a command byte, a direction flag, a one-or-two data byte selector, a payload for writes, and five timing counts in system clock cycles: clock-low time, clock-high time, byte setup time, byte hold time and inter-byte halt time. The master then runs the whole frame: an address phase, one or two data bytes, and the return of the lines to their parked state.

Bits go out least significant first. Each bit starts when the clock falls, and the data line changes at that same edge. A command byte holds a 6-bit device address in bits 7:2 and a 2-bit register-type code in bits 1:0. The master sends this byte as it is. A short register write has one data byte. An extended register write has two: the extended address and then the value. In a read, the master stops driving the data line once the address byte is done. It samples one bit in the last cycle of each clock-low period and reports each assembled byte with a one-cycle strobe.

Top module: `l3ser_master`

## Requirements
- R1: Out of reset and whenever no transfer is running, `busy` is 0 and `l3Clk`, `l3Mode` and `l3DataOe` are all 0. At the end of a transfer, `done` pulses for exactly one cycle. In that same cycle `busy` falls and the three lines return low.
- R2: `startReq` is accepted only in a cycle where `busy` is 0. In the cycle after acceptance, `busy`, `l3Clk`, `l3Mode`, `l3DataOut` and `l3DataOe` are all 1. A `startReq` raised while `busy` is 1 has no effect on the frame in progress and does not start another one.
- R3: Every byte goes out as exactly 8 rising clock edges, bit 0 first. The data line changes only on a falling clock edge, so it is stable while the clock is high. The command byte (device address in bits 7:2, type code in bits 1:0) is sent unchanged as the first byte.
- R4: Inside a byte, each clock-low period lasts `tLow` cycles and each clock-high period lasts `tHigh` cycles. The exceptions are the periods named in R5, R6 and R7.
- R5: The address phase pulls the clock low at the start of its setup wait. The low period before the first address edge therefore lasts `tSetup + tLow` cycles.
- R6: After the last bit of any byte, the clock stays high for `tHigh + tHold` cycles. Between the address byte and the first data byte there is no halt: the clock stays high for `tHigh + tHold + tSetup` cycles.
- R7: A second data byte is preceded by a halt. The clock is low for `tHalt` cycles, rises once, and stays high for `tSetup` cycles before the first bit of that byte. That rise carries no data bit.
- R8: With `twoBytes` = 0 a frame has 16 rising edges (address plus one data byte). With `twoBytes` = 1 it has 25 (address, first data byte, halt rise, second data byte). In a write, `payload[7:0]` is the first data byte and `payload[15:8]` is the second.
- R9: In a read, `l3DataOe` is 0 from the setup of the first data byte until the end of the frame. Each data bit is `l3DataIn` as sampled in the last cycle of its clock-low period, assembled bit 0 first. After each data byte, `rdValid` pulses for one cycle with the byte on `rdData`. A write never raises `rdValid`.
- R10: A timing count of 0 is treated as 1.
- R11: `l3Mode` is 1 in every cycle where `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Transfer request, taken only while idle |
| isRead | input | 1 | 1 selects a read frame, 0 a write frame |
| twoBytes | input | 1 | 1 selects two data bytes, 0 selects one |
| cmdByte | input | 8 | Command byte: device address in 7:2, type code in 1:0 |
| payload | input | 16 | Write data: first byte in 7:0, second byte in 15:8 |
| tLow | input | CW | Clock-low cycles per bit |
| tHigh | input | CW | Clock-high cycles per bit |
| tSetup | input | CW | Wait before the bits of each byte |
| tHold | input | CW | Wait after the bits of each byte |
| tHalt | input | CW | Clock-low halt before the second data byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| rdValid | output | 1 | One-cycle strobe for a received byte |
| rdData | output | 8 | Received byte, valid with rdValid |
| l3Clk | output | 1 | Serial clock line |
| l3Mode | output | 1 | Mode line |
| l3DataOut | output | 1 | Serial data value to drive |
| l3DataOe | output | 1 | Drive enable for the data line |
| l3DataIn | input | 1 | Serial data as seen on the line |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle: `done` is high while the controller is already idle and sampling `startReq`. The bench provokes this by raising `startReq` in the `done` cycle, with no idle gap. It then judges the second frame the same way as any other frame: edge count, bit values, the length of every clock-low and clock-high period, and the received bytes. Separately, requests raised in the middle of a frame with a different command byte must leave that frame unchanged, and `busy` must stay low afterwards.

// File: rtl/l3ser_pkg.sv
package l3ser_pkg;

  localparam int NUM_WAITS = 5;

  typedef enum logic [2:0] {
    W_LOW   = 3'd0,
    W_HIGH  = 3'd1,
    W_SETUP = 3'd2,
    W_HOLD  = 3'd3,
    W_HALT  = 3'd4
  } waitSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_SETUP,
    ST_BLO,
    ST_BHI,
    ST_HOLD,
    ST_HALT
  } l3State_e;

  // strobes from the sequencer to the datapath, all single-cycle
  typedef struct packed {
    logic       latchCfg;
    logic       openLines;
    logic       closeLines;
    logic       clkLo;
    logic       clkHi;
    logic       loadByte;
    logic [1:0] byteSel;
    logic       shiftOut;
    logic       sampleIn;
    logic       releaseData;
    logic       emitRead;
    logic       loadWait;
    waitSel_e   waitSel;
  } l3Strobe_t;

endpackage

// File: rtl/l3ser_dpath.sv
module l3ser_dpath
  import l3ser_pkg::*;
#(
  parameter int CW    = 8,
  parameter int BW    = 8,
  parameter int NDATA = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  l3Strobe_t           stb,
  input  logic [CW-1:0]       tLow,
  input  logic [CW-1:0]       tHigh,
  input  logic [CW-1:0]       tSetup,
  input  logic [CW-1:0]       tHold,
  input  logic [CW-1:0]       tHalt,
  input  logic [BW-1:0]       cmdByte,
  input  logic [NDATA*BW-1:0] payload,
  input  logic                l3DataIn,
  output logic                waitDone,
  output logic                l3Clk,
  output logic                l3Mode,
  output logic                l3DataOut,
  output logic                l3DataOe,
  output logic                rdValid,
  output logic [BW-1:0]       rdData
);

  localparam int NFRAME = NDATA + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] tIn  [NUM_WAITS];
  logic [CW-1:0] tReg [NUM_WAITS];
  logic [BW-1:0] frame [NFRAME];
  logic [BW-1:0] txSh;
  logic [BW-1:0] rxSh;
  logic [CW-1:0] waitCnt;
  logic [CW-1:0] waitVal;
  logic [BW-1:0] byteVal;

  assign tIn[0] = tLow;
  assign tIn[1] = tHigh;
  assign tIn[2] = tSetup;
  assign tIn[3] = tHold;
  assign tIn[4] = tHalt;

  // timing counts captured at start, zero clamped to one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WAITS; i++) tReg[i] <= ONE;
    end else if (stb.latchCfg) begin
      for (int i = 0; i < NUM_WAITS; i++) tReg[i] <= (tIn[i] == '0) ? ONE : tIn[i];
    end
  end

  // frame bytes captured at start: command first, then data bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NFRAME; k++) frame[k] <= '0;
    end else if (stb.latchCfg) begin
      frame[0] <= cmdByte;
      for (int k = 0; k < NDATA; k++) frame[k+1] <= payload[k*BW +: BW];
    end
  end

  always_comb begin
    case (stb.waitSel)
      W_LOW:   waitVal = tReg[0];
      W_HIGH:  waitVal = tReg[1];
      W_SETUP: waitVal = tReg[2];
      W_HOLD:  waitVal = tReg[3];
      W_HALT:  waitVal = tReg[4];
      default: waitVal = ONE;
    endcase
  end

  always_comb begin
    case (stb.byteSel)
      2'd0:    byteVal = frame[0];
      2'd1:    byteVal = frame[1];
      2'd2:    byteVal = frame[2];
      default: byteVal = '0;
    endcase
  end

  // shared phase timer: loaded with length-1, reports its last cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                waitCnt <= '0;
    else if (stb.loadWait)    waitCnt <= waitVal - ONE;
    else if (waitCnt != '0)   waitCnt <= waitCnt - ONE;
  end
  assign waitDone = (waitCnt == '0);

  // line drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l3Clk     <= 1'b0;
      l3Mode    <= 1'b0;
      l3DataOut <= 1'b0;
      l3DataOe  <= 1'b0;
      txSh      <= '0;
    end else begin
      if (stb.openLines) begin
        l3Clk     <= 1'b1;
        l3Mode    <= 1'b1;
        l3DataOut <= 1'b1;
        l3DataOe  <= 1'b1;
      end
      if (stb.closeLines) begin
        l3Clk     <= 1'b0;
        l3Mode    <= 1'b0;
        l3DataOut <= 1'b0;
        l3DataOe  <= 1'b0;
      end
      if (stb.clkLo)       l3Clk    <= 1'b0;
      if (stb.clkHi)       l3Clk    <= 1'b1;
      if (stb.releaseData) l3DataOe <= 1'b0;
      if (stb.loadByte)    txSh     <= byteVal;
      if (stb.shiftOut) begin
        l3DataOut <= txSh[0];
        txSh      <= txSh >> 1;
      end
    end
  end

  // receive path, LSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh    <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.emitRead;
      if (stb.sampleIn) rxSh   <= {l3DataIn, rxSh[BW-1:1]};
      if (stb.emitRead) rdData <= rxSh;
    end
  end

endmodule

// File: rtl/l3ser_ctrl.sv
module l3ser_ctrl
  import l3ser_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      isRead,
  input  logic      twoBytes,
  input  logic      waitDone,
  output l3Strobe_t stb,
  output logic      busy,
  output logic      done
);

  localparam int BITW = (BW > 1) ? $clog2(BW) : 1;
  localparam logic [BITW-1:0] LAST_BIT = BITW'(BW - 1);

  l3State_e        state, nxt;
  logic [1:0]      byteIdx, byteNxt;
  logic [BITW-1:0] bitIdx, bitNxt;
  logic            rdMode, twoMode, finish;
  logic [1:0]      lastIdx;

  assign lastIdx = twoMode ? 2'd2 : 2'd1;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb         = '0;
    stb.waitSel = W_LOW;
    nxt         = state;
    byteNxt     = byteIdx;
    bitNxt      = bitIdx;
    finish      = 1'b0;
    case (state)
      ST_IDLE: if (startReq) begin
        stb.latchCfg  = 1'b1;
        stb.openLines = 1'b1;
        byteNxt       = 2'd0;
        nxt           = ST_OPEN;
      end
      ST_OPEN: begin
        stb.clkLo    = 1'b1;
        stb.loadByte = 1'b1;
        stb.byteSel  = 2'd0;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_SETUP;
        nxt          = ST_SETUP;
      end
      ST_SETUP: if (waitDone) begin
        stb.clkLo    = 1'b1;
        stb.shiftOut = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_LOW;
        bitNxt       = '0;
        nxt          = ST_BLO;
      end
      ST_BLO: if (waitDone) begin
        stb.clkHi    = 1'b1;
        stb.sampleIn = rdMode && (byteIdx != 2'd0);
        stb.loadWait = 1'b1;
        stb.waitSel  = W_HIGH;
        nxt          = ST_BHI;
      end
      ST_BHI: if (waitDone) begin
        if (bitIdx == LAST_BIT) begin
          stb.emitRead = rdMode && (byteIdx != 2'd0);
          stb.loadWait = 1'b1;
          stb.waitSel  = W_HOLD;
          nxt          = ST_HOLD;
        end else begin
          bitNxt       = bitIdx + 1'b1;
          stb.clkLo    = 1'b1;
          stb.shiftOut = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_LOW;
          nxt          = ST_BLO;
        end
      end
      ST_HOLD: if (waitDone) begin
        if (byteIdx == lastIdx) begin
          stb.closeLines = 1'b1;
          finish         = 1'b1;
          nxt            = ST_IDLE;
        end else if (byteIdx == 2'd0) begin
          byteNxt         = 2'd1;
          stb.loadByte    = 1'b1;
          stb.byteSel     = 2'd1;
          stb.releaseData = rdMode;
          stb.loadWait    = 1'b1;
          stb.waitSel     = W_SETUP;
          nxt             = ST_SETUP;
        end else begin
          byteNxt      = 2'd2;
          stb.loadByte = 1'b1;
          stb.byteSel  = 2'd2;
          stb.clkLo    = 1'b1;
          stb.loadWait = 1'b1;
          stb.waitSel  = W_HALT;
          nxt          = ST_HALT;
        end
      end
      ST_HALT: if (waitDone) begin
        stb.clkHi    = 1'b1;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_SETUP;
        nxt          = ST_SETUP;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
      bitIdx  <= '0;
      rdMode  <= 1'b0;
      twoMode <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= nxt;
      byteIdx <= byteNxt;
      bitIdx  <= bitNxt;
      done    <= finish;
      if (stb.latchCfg) begin
        rdMode  <= isRead;
        twoMode <= twoBytes;
      end
    end
  end

endmodule

// File: rtl/l3ser_master.sv
module l3ser_master
  import l3ser_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          isRead,
  input  logic          twoBytes,
  input  logic [7:0]    cmdByte,
  input  logic [15:0]   payload,
  input  logic [CW-1:0] tLow,
  input  logic [CW-1:0] tHigh,
  input  logic [CW-1:0] tSetup,
  input  logic [CW-1:0] tHold,
  input  logic [CW-1:0] tHalt,
  output logic          busy,
  output logic          done,
  output logic          rdValid,
  output logic [7:0]    rdData,
  output logic          l3Clk,
  output logic          l3Mode,
  output logic          l3DataOut,
  output logic          l3DataOe,
  input  logic          l3DataIn
);

  localparam int BW    = 8;
  localparam int NDATA = 2;

  l3Strobe_t stb;
  logic      waitDone;

  l3ser_ctrl #(.BW(BW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .isRead   (isRead),
    .twoBytes (twoBytes),
    .waitDone (waitDone),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  l3ser_dpath #(.CW(CW), .BW(BW), .NDATA(NDATA)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tLow      (tLow),
    .tHigh     (tHigh),
    .tSetup    (tSetup),
    .tHold     (tHold),
    .tHalt     (tHalt),
    .cmdByte   (cmdByte),
    .payload   (payload),
    .l3DataIn  (l3DataIn),
    .waitDone  (waitDone),
    .l3Clk     (l3Clk),
    .l3Mode    (l3Mode),
    .l3DataOut (l3DataOut),
    .l3DataOe  (l3DataOe),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

endmodule

// File: rtl/l3ser_checker.sv
module l3ser_checker (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic busy,
  input logic done,
  input logic rdValid,
  input logic l3Clk,
  input logic l3Mode,
  input logic l3DataOut,
  input logic l3DataOe
);

  a_r1_idle_lines_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!l3Clk && !l3Mode && !l3DataOe));

  a_r1_done_closes: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !l3Clk && !l3Mode && !l3DataOe));

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  a_r2_open_all_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (l3Clk && l3Mode && l3DataOut && l3DataOe));

  a_r3_data_still_on_high: assert property (@(posedge clk) disable iff (!rstN)
    (l3Clk && $past(l3Clk)) |-> $stable(l3DataOut));

  a_r9_rdvalid_single: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r9_rdvalid_released: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !l3DataOe);

  a_r11_mode_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> l3Mode);

endmodule

bind l3ser_master l3ser_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .busy      (busy),
  .done      (done),
  .rdValid   (rdValid),
  .l3Clk     (l3Clk),
  .l3Mode    (l3Mode),
  .l3DataOut (l3DataOut),
  .l3DataOe  (l3DataOe)
);

// File: tb/sim_l3ser_master.sv
`timescale 1ns/1ps
module sim_l3ser_master;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        isRead = 1'b0;
  logic        twoBytes = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic [15:0] payload = '0;
  logic [7:0]  tLow = 8'd1, tHigh = 8'd1, tSetup = 8'd1, tHold = 8'd1, tHalt = 8'd1;
  logic        busy, done, rdValid;
  logic [7:0]  rdData;
  logic        l3Clk, l3Mode, l3DataOut, l3DataOe;
  logic        l3DataIn = 1'b0;

  l3ser_master #(.CW(8)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isRead(isRead), .twoBytes(twoBytes),
    .cmdByte(cmdByte), .payload(payload), .tLow(tLow), .tHigh(tHigh), .tSetup(tSetup),
    .tHold(tHold), .tHalt(tHalt), .busy(busy), .done(done), .rdValid(rdValid),
    .rdData(rdData), .l3Clk(l3Clk), .l3Mode(l3Mode), .l3DataOut(l3DataOut),
    .l3DataOe(l3DataOe), .l3DataIn(l3DataIn)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // expected-frame configuration of the transfer in flight
  logic [7:0]  eCmd;
  logic [15:0] ePay, eRx;
  bit          eTwo, eRd;
  int          cL, cH, cS, cO, cA;

  // line monitor state
  bit   prevClk = 0, prevBusy = 0;
  int   eIdx = 0, runLen = 0;
  int   lowLen [32];
  int   highLen[32];
  bit   eBit [32];
  bit   eOe  [32];
  bit   eMode[32];
  int   rdCnt = 0;
  logic [7:0] rdGot[4];
  bit   rdWide = 0, prevRdV = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  function automatic int numEdges();
    return eTwo ? 25 : 16;
  endfunction

  function automatic int expLow(input int e);
    if (e == 0) return cS + cL;
    if (eTwo && e == 16) return cA;
    return cL;
  endfunction

  function automatic int expHigh(input int e);
    if (e == 7) return cH + cO + cS;
    if (e == numEdges() - 1) return cH + cO;
    if (eTwo && e == 15) return cH + cO;
    if (eTwo && e == 16) return cS;
    return cH;
  endfunction

  function automatic bit expBit(input int e);
    if (e < 8) return eCmd[e];
    if (e < 16) return ePay[e-8];
    return ePay[8 + e - 17];
  endfunction

  function automatic bit rxBit(input int e);
    if (e >= 8 && e < 16) return eRx[e-8];
    if (e >= 17 && e < 25) return eRx[8 + e - 17];
    return 1'b0;
  endfunction

  // pin monitor acting as the codec side
  always @(negedge clk) begin
    cycles++;
    if (busy && !prevBusy) begin
      eIdx   = 0;
      runLen = 1;
    end else if (busy && prevBusy) begin
      if (l3Clk && !prevClk) begin
        if (eIdx < 32) begin
          lowLen[eIdx] = runLen;
          eBit[eIdx]   = l3DataOut;
          eOe[eIdx]    = l3DataOe;
          eMode[eIdx]  = l3Mode;
        end
        eIdx++;
        runLen = 1;
      end else if (!l3Clk && prevClk) begin
        if (eIdx > 0 && eIdx <= 32) highLen[eIdx-1] = runLen;
        runLen   = 1;
        l3DataIn = rxBit(eIdx);
      end else begin
        runLen++;
      end
    end else if (!busy && prevBusy) begin
      if (prevClk && eIdx > 0 && eIdx <= 32) highLen[eIdx-1] = runLen;
    end
    if (rdValid) begin
      if (rdCnt < 4) rdGot[rdCnt] = rdData;
      rdCnt++;
    end
    if (rdValid && prevRdV) rdWide = 1;
    prevRdV  = rdValid;
    prevClk  = l3Clk;
    prevBusy = busy;
  end

  // caller is positioned just after a falling clock edge
  task automatic doXfer(input logic [7:0] c, input logic [15:0] p, input bit two,
                        input bit rd, input logic [15:0] rx,
                        input logic [7:0] tl, input logic [7:0] th, input logic [7:0] ts,
                        input logic [7:0] tho, input logic [7:0] tha, input bit poke);
    int wait_n;
    bit seenDone;
    eCmd = c; ePay = p; eTwo = two; eRd = rd; eRx = rx;
    cL = clampv(tl); cH = clampv(th); cS = clampv(ts); cO = clampv(tho); cA = clampv(tha);
    rdCnt = 0; rdWide = 0;
    cmdByte = c; payload = p; twoBytes = two; isRead = rd;
    tLow = tl; tHigh = th; tSetup = ts; tHold = tho; tHalt = tha;
    startReq = 1'b1;
    @(negedge clk); #1;
    startReq = 1'b0;
    chk(busy && l3Clk && l3Mode && l3DataOut && l3DataOe, "R2 open",
        {busy, l3Clk, l3Mode, l3DataOut, l3DataOe}, 31);
    wait_n = 0;
    seenDone = 0;
    while (!seenDone && wait_n < 6000) begin
      @(negedge clk); #1;
      wait_n++;
      if (poke && wait_n == 3) begin
        startReq = 1'b1;
        cmdByte  = ~c;
        payload  = ~p;
      end else if (poke && wait_n == 4) begin
        startReq = 1'b0;
        cmdByte  = c;
        payload  = p;
      end
      if (done) seenDone = 1;
    end
    chk(seenDone, "R1 done seen", seenDone, 1);
    chk(!busy && !l3Clk && !l3Mode && !l3DataOe, "R1 lines low at done",
        {busy, l3Clk, l3Mode, l3DataOe}, 0);
    chk(eIdx == numEdges(), "R8 edge count", eIdx, numEdges());
    for (int e = 0; e < numEdges() && e < 32; e++) begin
      string tl_tag, th_tag;
      tl_tag = (e == 0) ? "R5 addr low" : ((eTwo && e == 16) ? "R7 halt low" : "R4 low");
      th_tag = (e == 7 || e == numEdges()-1 || (eTwo && e == 15)) ? "R6 high" :
               ((eTwo && e == 16) ? "R7 halt high" : "R4 high");
      chk(lowLen[e] == expLow(e), tl_tag, lowLen[e], expLow(e));
      chk(highLen[e] == expHigh(e), th_tag, highLen[e], expHigh(e));
      chk(eMode[e] == 1'b1, "R11 mode", eMode[e], 1);
      chk(eOe[e] == ((e < 8) || !eRd), "R9 drive enable", eOe[e], ((e < 8) || !eRd));
      if (!(eTwo && e == 16) && (e < 8 || !eRd))
        chk(eBit[e] == expBit(e), "R3 bit", eBit[e], expBit(e));
    end
    chk(rdCnt == (eRd ? (eTwo ? 2 : 1) : 0), "R9 read strobes", rdCnt, eRd ? (eTwo ? 2 : 1) : 0);
    chk(!rdWide, "R9 strobe width", rdWide, 0);
    if (eRd) begin
      chk(rdGot[0] == eRx[7:0], "R9 first byte", rdGot[0], eRx[7:0]);
      if (eTwo) chk(rdGot[1] == eRx[15:8], "R9 second byte", rdGot[1], eRx[15:8]);
    end
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); #1;
        chk(!busy, "R2 ignored start", busy, 0);
      end
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !l3Clk && !l3Mode && !l3DataOe && !rdValid, "R1 reset state",
        {busy, done, l3Clk, l3Mode, l3DataOe, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !l3Clk && !l3Mode, "R1 idle after reset", {busy, l3Clk, l3Mode}, 0);

    // directed: short write, unit timing
    doXfer(8'b0001_0100, 16'h00A5, 0, 0, 16'h0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 0);
    @(negedge clk); #1;
    chk(!done, "R1 done one cycle", done, 0);
    // directed: extended write with distinct timings
    doXfer(8'b0001_0110, 16'h3CC1, 1, 0, 16'h0, 8'd2, 8'd3, 8'd4, 8'd2, 8'd5, 0);
    // back-to-back: request raised in the done cycle (R2)
    doXfer(8'b1001_0101, 16'hFFFF, 1, 1, 16'h5AC3, 8'd3, 8'd1, 8'd2, 8'd1, 8'd3, 0);
    doXfer(8'b0000_0011, 16'h0000, 0, 1, 16'h0081, 8'd1, 8'd2, 8'd1, 8'd3, 8'd1, 0);
    // all-zero timing counts behave as one (R10)
    @(negedge clk); #1;
    doXfer(8'hF0, 16'h1234, 1, 0, 16'h0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 0);
    chk(lowLen[0] == 2, "R10 zero clamp", lowLen[0], 2);
    // request while busy is ignored (R2)
    @(negedge clk); #1;
    doXfer(8'h5A, 16'hC3E7, 1, 0, 16'h0, 8'd2, 8'd2, 8'd1, 8'd1, 8'd2, 1);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] rc;
      logic [15:0] rp, rr;
      int gap;
      rc  = 8'($urandom);
      rp  = 16'($urandom);
      rr  = 16'($urandom);
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); #1;
      end
      doXfer(rc, rp, 1'($urandom % 2), 1'($urandom % 2), rr,
             8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4),
             8'($urandom % 4), 8'($urandom % 4), (i % 7) == 3);
    end

    @(negedge clk); #1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule